// File: doc/BRIEF.md
# I2C Master Data Buffer

A four-byte holding store placed between a byte-wide host register port and an I2C master transfer engine. The host appends bytes with a write strobe and removes the oldest byte with a read strobe. The read strobe returns the head byte in the same cycle, and the remaining bytes move one place toward the head. After a receive transfer, the engine can load the whole store at once and set how many bytes are valid. A flush input empties the store.

The block drives two status flags, "has data" and "full". Neither flag is decoded from the fill count. Each changes only at particular fill transitions, and an engine load can only set a flag, never clear one. The fill count is also brought out on a port. Reading an empty store returns all ones.

Top module: `mdata_buf`

## Requirements
- R1: After reset the fill level is 0, both flags are low, and rd_data reads 0xFF.
- R2: Host writes are stored in arrival order. Each host read returns the oldest stored byte on rd_data in the cycle of the read strobe, and the remaining bytes move toward the head.
- R3: A host write made while four bytes are held is ignored. The level stays 4 and the stored bytes are unchanged.
- R4: A host write that takes the level from 0 to 1 sets has_data. A host write that takes the level to 4 sets is_full.
- R5: A host read while the level is 0 returns 0xFF and changes neither the level nor the flags.
- R6: A host read taken at level 4 clears is_full. A host read that removes the last byte clears has_data.
- R7: flush empties the store, zeroes every stored byte and clears both flags. It overrides a load, a write or a read in the same cycle.
- R8: An engine load with count N from 1 to 4 sets the level to N. The stored bytes are taken from ld_data, with bits [7:0] as the oldest byte. The load sets has_data, and also sets is_full when N is 4. A load with count 0 or above 4 is ignored. Host strobes in the same cycle as a load are ignored.
- R9: When a host read and a host write occur in the same cycle, the read is serviced first and the write second. The flags follow that order.
- R10: The level output is a 3-bit count that never exceeds 4.
- R11: An engine load never clears a flag. A load of fewer than 4 bytes made while is_full is set leaves is_full set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Head byte, or 0xFF when empty |
| ld_en | input | 1 | Engine bulk load strobe |
| ld_data | input | 32 | Bytes to load, oldest in bits [7:0] |
| ld_cnt | input | 3 | Number of bytes to load |
| flush | input | 1 | Empty the store and clear the flags |
| level | output | 3 | Current fill count |
| has_data | output | 1 | "Has data" flag |
| is_full | output | 1 | "Full" flag |

## Verification
The bench first fills the store with single host writes and drains it with host reads. This shows that byte order is kept, that writes past four bytes are dropped, and that each flag moves at its own transition. Simultaneous read and write strobes are applied at empty and at full. Only read-before-write ordering gives the expected byte and level at those two points. Engine loads of three, four, zero and two bytes separate a valid load from an ignored one and show that a load leaves an existing is_full set. A flush given together with other strobes shows that flush takes priority.

// File: rtl/mdata_buf.sv
module mdata_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [W-1:0]       wr_data,
  input  logic               rd_en,
  output logic [W-1:0]       rd_data,
  input  logic               ld_en,
  input  logic [DEPTH*W-1:0] ld_data,
  input  logic [LW-1:0]      ld_cnt,
  input  logic               flush,
  output logic [LW-1:0]      level,
  output logic               has_data,
  output logic               is_full
);
  localparam logic [LW-1:0] TOP = LW'(DEPTH);
  localparam logic [LW-1:0] ONE = LW'(1);

  logic [W-1:0]  mem   [DEPTH];
  logic [W-1:0]  mem_n [DEPTH];
  logic [LW-1:0] lv_n;
  logic          has_n, full_n;
  logic          ld_ok;

  assign rd_data = (level == '0) ? {W{1'b1}} : mem[0];
  assign ld_ok   = ld_en && ld_cnt != '0 && ld_cnt <= TOP;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_n[i] = mem[i];
    lv_n   = level;
    has_n  = has_data;
    full_n = is_full;
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) mem_n[i] = '0;
      lv_n   = '0;
      has_n  = 1'b0;
      full_n = 1'b0;
    end else if (ld_ok) begin
      for (int i = 0; i < DEPTH; i++) mem_n[i] = ld_data[i*W +: W];
      lv_n  = ld_cnt;
      has_n = 1'b1;
      if (ld_cnt == TOP) full_n = 1'b1;
    end else begin
      if (rd_en && level != '0) begin
        for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem[i+1];
        mem_n[DEPTH-1] = '0;
        if (level == TOP) full_n = 1'b0;
        if (level == ONE) has_n  = 1'b0;
        lv_n = level - ONE;
      end
      if (wr_en && lv_n < TOP) begin
        for (int i = 0; i < DEPTH; i++)
          if (LW'(i) == lv_n) mem_n[i] = wr_data;
        lv_n = lv_n + ONE;
        if (lv_n == ONE) has_n  = 1'b1;
        if (lv_n == TOP) full_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      level    <= '0;
      has_data <= 1'b0;
      is_full  <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
      level    <= lv_n;
      has_data <= has_n;
      is_full  <= full_n;
    end
  end
endmodule

// File: rtl/mdata_buf_chk.sv
module mdata_buf_chk #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          ld_en,
  input logic [LW-1:0] ld_cnt,
  input logic          flush,
  input logic [W-1:0]  rd_data,
  input logic [LW-1:0] level,
  input logic          has_data,
  input logic          is_full
);
  localparam logic [LW-1:0] TOP = LW'(DEPTH);
  logic host_only;
  assign host_only = !ld_en && !flush;

  p_level_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    level <= TOP);

  p_empty_read_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0) |-> rd_data == {W{1'b1}});

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_only && wr_en && !rd_en && level == TOP) |=> (level == TOP && is_full));

  p_first_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_only && wr_en && !rd_en && level == '0) |=> (has_data && level == LW'(1)));

  p_full_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_only && rd_en && !wr_en && level == TOP) |=> !is_full);

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && !has_data && !is_full));

  p_full_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !flush && ld_cnt == TOP) |=> (is_full && has_data && level == TOP));

  p_load_keeps_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !flush && is_full) |=> is_full);
endmodule

bind mdata_buf mdata_buf_chk #(.DEPTH(DEPTH), .W(W), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .ld_en(ld_en),
  .ld_cnt(ld_cnt), .flush(flush), .rd_data(rd_data), .level(level),
  .has_data(has_data), .is_full(is_full)
);

// File: tb/mdata_buf_bench.sv
module mdata_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, ld_en = 1'b0, flush = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [31:0] ld_data = '0;
  logic [2:0]  ld_cnt = '0;
  logic [7:0]  rd_data;
  logic [2:0]  level;
  logic        has_data, is_full;

  int total = 0, bad = 0;
  bit done = 0;
  bit rd_chk = 0;
  string rd_tag = "";
  logic [7:0] model[$];
  logic [7:0] exp_q[$];
  bit m_has = 0, m_full = 0;

  mdata_buf u_mdata_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .ld_en(ld_en), .ld_data(ld_data), .ld_cnt(ld_cnt),
    .flush(flush), .level(level), .has_data(has_data), .is_full(is_full)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes and compares with rd_data
  always @(negedge clk) begin
    if (rd_en && rd_chk) begin
      if (exp_q.size() == 0) chk({rd_tag, " scoreboard underflow"}, 1, 0);
      else chk({rd_tag, " rd_data"}, rd_data, exp_q.pop_front());
    end
  end

  task automatic step(bit wr, logic [7:0] wd, bit rd, bit ld, logic [2:0] lc,
                      logic [31:0] ldat, bit fl, string tag);
    @(posedge clk); #1;
    wr_en = wr; wr_data = wd; rd_en = rd; ld_en = ld; ld_cnt = lc;
    ld_data = ldat; flush = fl; rd_tag = tag;
    rd_chk = rd && !fl && !(ld && lc >= 1 && lc <= 4);
    if (fl) begin
      model.delete(); m_has = 0; m_full = 0;
    end else if (ld && lc >= 1 && lc <= 4) begin
      model.delete();
      for (int i = 0; i < lc; i++) model.push_back(ldat[i*8 +: 8]);
      m_has = 1;
      if (lc == 4) m_full = 1;
    end else begin
      if (rd) begin
        if (model.size() == 0) exp_q.push_back(8'hFF);
        else begin
          if (model.size() == 4) m_full = 0;
          if (model.size() == 1) m_has = 0;
          exp_q.push_back(model.pop_front());
        end
      end
      if (wr && model.size() < 4) begin
        model.push_back(wd);
        if (model.size() == 1) m_has = 1;
        if (model.size() == 4) m_full = 1;
      end
    end
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; ld_en = 0; flush = 0; rd_chk = 0;
  endtask

  task automatic check_state(string tag);
    @(negedge clk);
    chk({tag, " level"}, level, model.size());
    chk({tag, " has_data"}, has_data, m_has);
    chk({tag, " is_full"}, is_full, m_full);
  endtask

  task automatic wr(logic [7:0] b, string t); step(1, b, 0, 0, 0, 0, 0, t); endtask
  task automatic rd(string t); step(0, 0, 1, 0, 0, 0, 0, t); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset level", level, 0);
    chk("R1 reset flags", {has_data, is_full}, 0);
    chk("R1 reset rd_data", rd_data, 8'hFF);

    rd("R5 empty read"); check_state("R5 empty read");
    wr(8'hA1, "R4"); check_state("R4 first write");
    wr(8'hA2, "R2"); check_state("R10 level two");
    wr(8'hA3, "R2"); wr(8'hA4, "R4"); check_state("R4 full write");
    wr(8'hA5, "R3"); check_state("R3 write at full");
    rd("R2 oldest first"); check_state("R6 read at full");
    rd("R2 order"); rd("R3 contents kept");
    rd("R2 last byte"); check_state("R6 last read");
    rd("R5 empty again"); check_state("R5 no change");

    step(1, 8'h5C, 1, 0, 0, 0, 0, "R9 rd+wr at empty"); check_state("R9 empty rd+wr");
    wr(8'h11, "R2"); wr(8'h22, "R2"); wr(8'h33, "R4");
    step(1, 8'h44, 1, 0, 0, 0, 0, "R9 rd+wr at full"); check_state("R9 full rd+wr");
    rd("R9 order"); rd("R9 order"); rd("R9 order"); rd("R9 order");
    check_state("R9 drained");

    wr(8'h77, "R2");
    step(1, 8'h88, 1, 1, 3'd2, 32'h01020304, 1, "R7 flush"); check_state("R7 flush priority");
    rd("R7 empty after flush");

    step(0, 0, 0, 1, 3'd3, 32'hDEC0B1A0, 0, "R8"); check_state("R8 load three");
    rd("R8 byte0"); rd("R8 byte1"); rd("R8 byte2"); check_state("R8 drained");
    step(0, 0, 0, 1, 3'd4, 32'h44332211, 0, "R8"); check_state("R8 load four");
    step(1, 8'h99, 1, 1, 3'd0, 32'hFFFFFFFF, 0, "R8 zero count"); check_state("R8 zero ignored");
    step(0, 0, 0, 1, 3'd5, 32'hFFFFFFFF, 0, "R8 over count"); check_state("R8 count 5 ignored");
    step(1, 8'h99, 1, 1, 3'd2, 32'h0000BEEF, 0, "R8 host blocked"); check_state("R11 load keeps full");
    rd("R11 byte0"); rd("R11 byte1"); check_state("R11 after drain");
    step(0, 0, 0, 0, 0, 0, 1, "R7"); check_state("R7 final flush");

    repeat (2) @(negedge clk);
    chk("R2 scoreboard empty", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule